// File: doc/BRIEF.md
# Cipher Key Cache Table

This block is the on-chip table of cipher keys used by a wireless MAC. It holds up to 128 slots. Each slot has five 32-bit key words, two 32-bit address words (low and high halves of a station address) and a 7-bit cipher code. Software fills a slot through a simple register port, one word per cycle, and reads any word back combinationally.

A separate clear port wipes one slot in a single cycle. The clear zeroes the slot's keys and address and marks it as carrying no cipher. If the slot held a TKIP key, its integrity-check companion slot, 64 positions higher, loses its first four key words in the same cycle. A capability input decides whether that companion also loses its fifth key word and is marked as carrying no cipher. A slot limit input bounds which clear requests are honoured. Every request gets a one-cycle done pulse with an ok flag.

Top module: `keycache_table`

## Requirements
- R1: After synchronous reset, every word of every slot reads zero and `clr_done` and `clr_ok` are low.
- R2: With `reg_we` high and `clr_req` low, `reg_wdata` is stored in the word picked by `reg_idx` and `reg_sel`. `reg_sel` codes 0–4 are key words 0–4, 5 is the address low word, 6 is the address high word and 7 is the cipher code. For the cipher code only bits 6:0 are kept and the rest read as zero. `reg_rdata` shows the selected word in the same cycle.
- R3: A clear request whose index is below `cfg_limit` produces `clr_done`=1 and `clr_ok`=1 in the next cycle. From then on the slot's key words 0–4 and both address words read zero and its cipher code reads 5 (clear). Cipher codes are WEP=0, AES-OCB=1, AES-CCM=2, CKIP=3, TKIP=4, clear=5 and MIC=127.
- R4: A clear request whose index is at or above `cfg_limit` produces `clr_done`=1 and `clr_ok`=0 in the next cycle and changes no slot.
- R5: When an accepted clear hits a slot whose code was 4 (TKIP) and whose index is below 64, key words 0–3 of slot index+64 become zero. When `cfg_caps[1]` is 0, that companion's key word 4 and cipher code are kept.
- R6: When `cfg_caps[1]` (combined MIC) is 1, the companion also gets key word 4 zeroed and cipher code 5. `cfg_caps[0]` (AES-CCM support) has no effect on clearing. The companion's address words are never changed.
- R7: A clear of a slot whose code is not TKIP, or of a TKIP slot at index 64 or above, leaves every other slot unchanged.
- R8: In the cycle a clear request is presented, `reg_rdata` still shows the slot's contents from before the clear.
- R9: A register write presented in the same cycle as a clear request is dropped.
- R10: `clr_done` is high for exactly the one cycle after each request cycle and low after any cycle without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_limit | input | 8 | Number of slots in use; clears at or above it are refused |
| cfg_caps | input | 2 | Bit 0 AES-CCM support, bit 1 combined MIC |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 7 | Slot index for register access |
| reg_sel | input | 3 | Word select within the slot |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected word, combinational |
| clr_req | input | 1 | Single-cycle clear request |
| clr_idx | input | 7 | Slot to clear |
| clr_done | output | 1 | Response pulse, one cycle after the request |
| clr_ok | output | 1 | Request was accepted |

## Verification
The hardest case to reach is the companion clear. It needs a slot below 64 that holds code 4 and a well-known companion at index+64, all within range. It also has to be tried with each setting of the combined-MIC bit and checked against slots at 64 and above that must not pair. The stimulus fills both slots of a pair with random words and then writes the TKIP code on purpose. About a third of the random clears aim at such prepared pairs. Each clear then reads back every word of the target and of its partner index. Random clears also carry a write to some other slot, to show that a colliding write is dropped.

// File: rtl/keycache_pkg.sv
package keycache_pkg;

    localparam int CODE_W    = 7;
    localparam int SLOT_WORDS = 8;
    localparam int KEY_WORDS = 5;
    localparam int SEL_W     = 3;

    typedef enum logic [CODE_W-1:0] {
        CIPH_WEP     = 7'd0,
        CIPH_AES_OCB = 7'd1,
        CIPH_AES_CCM = 7'd2,
        CIPH_CKIP    = 7'd3,
        CIPH_TKIP    = 7'd4,
        CIPH_CLEAR   = 7'd5,
        CIPH_MIC     = 7'd127
    } cipher_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_KEY0 = 3'd0,
        SEL_KEY1 = 3'd1,
        SEL_KEY2 = 3'd2,
        SEL_KEY3 = 3'd3,
        SEL_KEY4 = 3'd4,
        SEL_ADRL = 3'd5,
        SEL_ADRH = 3'd6,
        SEL_CODE = 3'd7
    } word_sel_e;

    localparam int CAP_CCM_BIT = 0;
    localparam int CAP_MIC_BIT = 1;

    typedef struct packed {
        logic       pri_en;
        logic       mic_en;
        logic       mic_full;
    } clr_plan_t;

endpackage

// File: rtl/keycache_clr_ctrl.sv
module keycache_clr_ctrl
    import keycache_pkg::*;
#(
    parameter int NUM_SLOTS  = 128,
    parameter int MIC_OFFSET = 64,
    localparam int IDX_W = $clog2(NUM_SLOTS),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_req,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic [CNT_W-1:0]  cfg_limit,
    input  logic [1:0]        cfg_caps,
    input  logic [CODE_W-1:0] cur_code,
    output clr_plan_t         plan,
    output logic [IDX_W-1:0]  mic_idx,
    output logic              done,
    output logic              ok
);
    logic             in_range;
    logic             has_partner;
    logic [CNT_W-1:0] partner_wide;

    always_comb begin
        in_range     = {1'b0, clr_idx} < cfg_limit;
        partner_wide = {1'b0, clr_idx} + CNT_W'(MIC_OFFSET);
        has_partner  = partner_wide < CNT_W'(NUM_SLOTS);
        mic_idx      = partner_wide[IDX_W-1:0];

        plan.pri_en   = clr_req && in_range;
        plan.mic_en   = plan.pri_en && has_partner && (cur_code == CIPH_TKIP);
        plan.mic_full = cfg_caps[CAP_MIC_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            ok   <= 1'b0;
        end else begin
            done <= clr_req;
            ok   <= clr_req && in_range;
        end
    end
endmodule

// File: rtl/keycache_store.sv
module keycache_store
    import keycache_pkg::*;
#(
    parameter int NUM_SLOTS = 128,
    parameter int DATA_W    = 32,
    localparam int IDX_W = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  pri_idx,
    input  clr_plan_t         plan,
    input  logic [IDX_W-1:0]  mic_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [CODE_W-1:0] pri_code
);
    logic [DATA_W-1:0] words [NUM_SLOTS][SLOT_WORDS];
    logic [DATA_W-1:0] wr_value;

    always_comb begin
        wr_value = wr_data;
        if (wr_sel == SEL_CODE)
            wr_value = DATA_W'(wr_data[CODE_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SLOTS; s++)
                for (int w = 0; w < SLOT_WORDS; w++)
                    words[s][w] <= '0;
        end else begin
            if (wr_en)
                words[wr_idx][wr_sel] <= wr_value;
            if (plan.pri_en) begin
                for (int w = 0; w < KEY_WORDS; w++)
                    words[pri_idx][w] <= '0;
                words[pri_idx][SEL_ADRL] <= '0;
                words[pri_idx][SEL_ADRH] <= '0;
                words[pri_idx][SEL_CODE] <= DATA_W'(CIPH_CLEAR);
            end
            if (plan.mic_en) begin
                for (int w = 0; w < KEY_WORDS - 1; w++)
                    words[mic_idx][w] <= '0;
                if (plan.mic_full) begin
                    words[mic_idx][SEL_KEY4] <= '0;
                    words[mic_idx][SEL_CODE] <= DATA_W'(CIPH_CLEAR);
                end
            end
        end
    end

    assign rd_data  = words[rd_idx][rd_sel];
    assign pri_code = words[pri_idx][SEL_CODE][CODE_W-1:0];
endmodule

// File: rtl/keycache_table.sv
module keycache_table
    import keycache_pkg::*;
#(
    parameter int NUM_SLOTS  = 128,
    parameter int DATA_W     = 32,
    parameter int MIC_OFFSET = 64,
    localparam int IDX_W = $clog2(NUM_SLOTS),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cfg_limit,
    input  logic [1:0]        cfg_caps,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              clr_req,
    input  logic [IDX_W-1:0]  clr_idx,
    output logic              clr_done,
    output logic              clr_ok
);
    clr_plan_t         plan;
    logic [IDX_W-1:0]  mic_idx;
    logic [CODE_W-1:0] cur_code;
    logic              wr_gate;

    assign wr_gate = reg_we && !clr_req;

    keycache_clr_ctrl #(
        .NUM_SLOTS (NUM_SLOTS),
        .MIC_OFFSET(MIC_OFFSET)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .clr_req  (clr_req),
        .clr_idx  (clr_idx),
        .cfg_limit(cfg_limit),
        .cfg_caps (cfg_caps),
        .cur_code (cur_code),
        .plan     (plan),
        .mic_idx  (mic_idx),
        .done     (clr_done),
        .ok       (clr_ok)
    );

    keycache_store #(
        .NUM_SLOTS(NUM_SLOTS),
        .DATA_W   (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_gate),
        .wr_idx  (reg_idx),
        .wr_sel  (reg_sel),
        .wr_data (reg_wdata),
        .pri_idx (clr_idx),
        .plan    (plan),
        .mic_idx (mic_idx),
        .rd_idx  (reg_idx),
        .rd_sel  (reg_sel),
        .rd_data (reg_rdata),
        .pri_code(cur_code)
    );
endmodule

// File: rtl/keycache_table_chk.sv
module keycache_table_chk #(
    parameter int IDX_W = 7,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_req,
    input logic [IDX_W-1:0] clr_idx,
    input logic [CNT_W-1:0] cfg_limit,
    input logic             clr_done,
    input logic             clr_ok
);
    // R10
    req_done_chk: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> clr_done);

    // R10
    idle_done_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_req |=> !clr_done);

    // R3
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req && ({1'b0, clr_idx} < cfg_limit)) |=> clr_ok);

    // R4
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req && ({1'b0, clr_idx} >= cfg_limit)) |=> !clr_ok);

    // R3
    ok_done_chk: assert property (@(posedge clk) disable iff (rst)
        clr_ok |-> clr_done);
endmodule

bind keycache_table keycache_table_chk #(
    .IDX_W(IDX_W),
    .CNT_W(CNT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr_req  (clr_req),
    .clr_idx  (clr_idx),
    .cfg_limit(cfg_limit),
    .clr_done (clr_done),
    .clr_ok   (clr_ok)
);

// File: tb/keycache_table_bench.sv
`timescale 1ns/1ps
module keycache_table_bench;
    localparam int N = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_limit = 8'd128;
    logic [1:0]  cfg_caps = 2'b00;
    logic        reg_we = 1'b0;
    logic [6:0]  reg_idx = '0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clr_req = 1'b0;
    logic [6:0]  clr_idx = '0;
    logic        clr_done;
    logic        clr_ok;

    int checks = 0;
    int errors = 0;
    logic [31:0] m [N][8];

    always #10 clk = ~clk;

    keycache_table u_keycache_table (
        .clk(clk), .rst(rst), .cfg_limit(cfg_limit), .cfg_caps(cfg_caps),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .clr_req(clr_req), .clr_idx(clr_idx),
        .clr_done(clr_done), .clr_ok(clr_ok)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic logic [31:0] expect_ok(logic [6:0] idx);
        return {31'd0, ({1'b0, idx} < cfg_limit)};
    endfunction

    task automatic model_clear(logic [6:0] idx);
        logic [31:0] was;
        if ({1'b0, idx} >= cfg_limit) return;
        was = m[idx][7];
        for (int w = 0; w < 7; w++) m[idx][w] = '0;
        m[idx][7] = 32'd5;
        if (was == 32'd4 && idx < 7'd64) begin
            for (int w = 0; w < 4; w++) m[idx + 7'd64][w] = '0;
            if (cfg_caps[1]) begin
                m[idx + 7'd64][4] = '0;
                m[idx + 7'd64][7] = 32'd5;
            end
        end
    endtask

    task automatic rd(logic [6:0] idx, logic [2:0] sel, string tag);
        @(negedge clk);
        reg_idx = idx;
        reg_sel = sel;
        #1;
        chk(tag, reg_rdata, m[idx][sel]);
    endtask

    task automatic wr(logic [6:0] idx, logic [2:0] sel, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_idx = idx;
        reg_sel = sel;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        m[idx][sel] = (sel == 3'd7) ? {25'd0, d[6:0]} : d;
    endtask

    task automatic fill(logic [6:0] idx, logic [6:0] code);
        for (int w = 0; w < 7; w++) wr(idx, 3'(w), $urandom);
        wr(idx, 3'd7, {$urandom, code});
    endtask

    task automatic slot_check(logic [6:0] idx, string tag);
        for (int w = 0; w < 8; w++) rd(idx, 3'(w), tag);
    endtask

    task automatic do_clr(logic [6:0] idx, bit try_we, logic [6:0] widx, string tag);
        @(negedge clk);
        clr_req = 1'b1;
        clr_idx = idx;
        if (try_we) begin
            reg_we = 1'b1;
            reg_idx = widx;
            reg_sel = 3'd5;
            reg_wdata = ~m[widx][5];
            #1;
            chk("R8 pre-clear read", reg_rdata, m[widx][5]);
        end else begin
            reg_idx = idx;
            reg_sel = 3'd7;
            #1;
            chk("R8 pre-clear read", reg_rdata, m[idx][7]);
        end
        @(negedge clk);
        clr_req = 1'b0;
        reg_we = 1'b0;
        chk("R10 done pulse", {31'd0, clr_done}, 32'd1);
        chk({tag, " R3/R4 ok"}, {31'd0, clr_ok}, expect_ok(idx));
        model_clear(idx);
        #1;
        chk("R8 post-edge read", reg_rdata, m[reg_idx][reg_sel]);
        @(negedge clk);
        chk("R10 done low", {31'd0, clr_done}, 32'd0);
        slot_check(idx, {tag, " R3 slot"});
        slot_check(idx ^ 7'd64, {tag, " R5/R6/R7 partner"});
        if (try_we) rd(widx, 3'd5, "R9 dropped write");
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int s = 0; s < N; s++)
            for (int w = 0; w < 8; w++) m[s][w] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 done after reset", {31'd0, clr_done}, 32'd0);
        chk("R1 ok after reset", {31'd0, clr_ok}, 32'd0);
        rd(7'd0, 3'd0, "R1 slot0 key0");
        rd(7'd127, 3'd7, "R1 slot127 code");
        slot_check(7'd77, "R1 slot77");

        // R2 code field masking
        wr(7'd10, 3'd7, 32'hFFFF_FF84);
        rd(7'd10, 3'd7, "R2 code mask");
        wr(7'd10, 3'd2, 32'hDEAD_BEEF);
        rd(7'd10, 3'd2, "R2 key word");

        // R5 TKIP without combined MIC
        cfg_limit = 8'd128;
        cfg_caps = 2'b01;
        fill(7'd3, 7'd4);
        fill(7'd67, 7'd127);
        do_clr(7'd3, 1'b0, 7'd0, "R5 tkip caps0");

        // R6 TKIP with combined MIC
        cfg_caps = 2'b10;
        fill(7'd20, 7'd4);
        fill(7'd84, 7'd127);
        do_clr(7'd20, 1'b0, 7'd0, "R6 tkip caps1");

        // R7 non-TKIP and high TKIP
        fill(7'd30, 7'd2);
        fill(7'd94, 7'd127);
        do_clr(7'd30, 1'b0, 7'd0, "R7 ccm");
        fill(7'd100, 7'd4);
        fill(7'd36, 7'd4);
        do_clr(7'd100, 1'b0, 7'd0, "R7 high tkip");

        // R4 out of range, including limit 0
        cfg_limit = 8'd50;
        fill(7'd50, 7'd4);
        fill(7'd114, 7'd127);
        do_clr(7'd50, 1'b0, 7'd0, "R4 at limit");
        cfg_limit = 8'd0;
        fill(7'd0, 7'd1);
        do_clr(7'd0, 1'b0, 7'd0, "R4 limit zero");
        cfg_limit = 8'd128;
        fill(7'd127, 7'd0);
        do_clr(7'd127, 1'b0, 7'd0, "R3 last slot");

        // R9 colliding write
        fill(7'd40, 7'd3);
        do_clr(7'd5, 1'b1, 7'd40, "R9 collide");

        // random mix
        for (int i = 0; i < 200; i++) begin
            logic [6:0] idx;
            int op;
            idx = 7'($urandom_range(0, 127));
            op = $urandom_range(0, 9);
            cfg_caps = 2'($urandom);
            cfg_limit = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 128)) : 8'd128;
            if (op < 3) begin
                idx[6] = 1'b0;
                fill(idx, 7'd4);
                fill(idx + 7'd64, ($urandom_range(0, 1) != 0) ? 7'd127 : 7'd4);
                do_clr(idx, 1'b0, 7'd0, "R5/R6 random pair");
            end else if (op < 6) begin
                wr(idx, 3'($urandom), $urandom);
                rd(idx, 3'($urandom), "R2 random read");
            end else begin
                do_clr(idx, $urandom_range(0, 1) != 0, 7'($urandom), "R3/R4 random");
            end
        end

        for (int s = 0; s < N; s++) slot_check(7'(s), "R2 final sweep");
        summary();
    end
endmodule